// File: doc/BRIEF.md
# Three-Master Bus Owner Arbiter with Debug Escalation

This block decides which of three masters may drive a single shared target bus: a main processor (index 0), a coprocessor (index 1) and a debug master (index 2). Each master raises a request and, while it owns the bus, pulses a done flag on the cycle its current transfer ends. The arbiter answers with a registered one-hot grant vector and a registered per-master stall vector. Ownership never moves in the middle of a transfer. The bus changes hands only at a handover point: the bus is idle, the owner has dropped its request, or the owner signals done.

At a handover the normal ranking is main, then coprocessor, then debug. Two rules override it. A coprocessor request marked as a special-register access wins every handover, and the main processor stalls while that access lasts. The arbiter also counts the consecutive cycles in which the debug master is refused. Once that count passes a limit (128 by default), the debug master becomes escalated. It still lets the current owner finish, but it takes the next handover. Escalation ends when the escalated debug transfer finishes or when the debug master withdraws its request.

Top module: `bus_owner_arbiter`

## Requirements
- R1: `grant_o` is one-hot or zero in every cycle; bit 0 is the main processor, bit 1 the coprocessor, bit 2 the debug master.
- R2: `grant_o` changes only one cycle after a handover cycle. A handover cycle is one where nothing is granted, or the owner's `req_i` bit is low, or the owner's `done_i` bit is high. A `done_i` bit from a master that is not the owner has no effect.
- R3: With no special access and no escalation, a handover grants the requesting master with the lowest index (main over coprocessor over debug). If nobody requests, nothing is granted.
- R4: When `req_i[1]` and `cop_special_i` are both high in a handover cycle, the coprocessor is granted next, ahead of the main processor and ahead of an escalated debug master.
- R5: Escalation is set at the end of the cycle in which the debug master completes its WAIT_LIMIT+1-th (129th by default) consecutive cycle of requesting without being selected. While escalated, the debug master wins every handover except one taken by a special coprocessor access.
- R6: Escalation is cleared when the debug master is the owner and raises `done_i[2]`, and also when `req_i[2]` is low. The handover in which the escalated transfer finishes follows normal priority.
- R7: The debug refusal count restarts from zero whenever the debug master is selected or drops its request for a cycle, so two waits that are each shorter than the limit and separated by such a cycle do not escalate.
- R8: `stall_o[i]` is high in the cycle after a cycle where `req_i[i]` was high and master i was not selected for the grant that follows, i.e. `stall_o == past(req_i) & ~grant_o`.
- R9: While `rst` is high, and in the first cycle after it, `grant_o` and `stall_o` are zero and the refusal count and escalation are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 3 | Request per master (0 main, 1 coprocessor, 2 debug) |
| done_i | input | 3 | Transfer-complete flag per master, used only for the owner |
| cop_special_i | input | 1 | Coprocessor request is a special-register access |
| grant_o | output | 3 | Registered one-hot grant |
| stall_o | output | 3 | Registered stall per master |

## Verification
The hardest state to reach is escalation. The debug master has to be refused for more than 128 consecutive cycles while a higher master keeps winning real handovers, and the handover right after escalation has to be seen to go to the debug master. The stimulus keeps the main processor requesting for a long stretch and pulses its done flag every few cycles, so handovers keep occurring and the main processor keeps winning them. A second run breaks the wait with a one-cycle request drop to show the count restarting, and a third puts a special coprocessor access against an already escalated debug master. A behavioural model in the bench predicts grant and stall for every cycle.

// File: rtl/boa_pkg.sv
package boa_pkg;
  localparam int unsigned N_MST  = 3;
  localparam int unsigned M_MAIN = 0;
  localparam int unsigned M_COP  = 1;
  localparam int unsigned M_DBG  = 2;

  typedef logic [N_MST-1:0] mvec_t;
endpackage

// File: rtl/boa_handover.sv
module boa_handover
  import boa_pkg::*;
(
  input  mvec_t grant_q,
  input  mvec_t req_i,
  input  mvec_t done_i,
  output logic  handover_o,
  output logic  dbg_finish_o
);
  logic idle;
  logic owner_left;
  logic owner_done;

  always_comb begin
    idle       = (grant_q == '0);
    owner_left = |(grant_q & ~req_i);
    owner_done = |(grant_q & done_i);
    handover_o = idle | owner_left | owner_done;
    dbg_finish_o = grant_q[M_DBG] & done_i[M_DBG];
  end
endmodule

// File: rtl/boa_pick.sv
module boa_pick
  import boa_pkg::*;
(
  input  logic  handover_i,
  input  mvec_t grant_q,
  input  mvec_t req_i,
  input  logic  special_i,
  input  logic  esc_eff_i,
  output mvec_t grant_nxt_o
);
  mvec_t normal_pick;

  // Lowest index wins in the normal ranking.
  always_comb begin
    normal_pick = '0;
    for (int k = 0; k < int'(N_MST); k++) begin
      if (req_i[k] && (normal_pick == '0)) normal_pick[k] = 1'b1;
    end
  end

  always_comb begin
    grant_nxt_o = grant_q;
    if (handover_i) begin
      grant_nxt_o = '0;
      if (req_i[M_COP] && special_i)
        grant_nxt_o[M_COP] = 1'b1;
      else if (esc_eff_i && req_i[M_DBG])
        grant_nxt_o[M_DBG] = 1'b1;
      else
        grant_nxt_o = normal_pick;
    end
  end
endmodule

// File: rtl/boa_wait_tracker.sv
module boa_wait_tracker #(
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned WAIT_LIMIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic dbg_req_i,
  input  logic dbg_sel_i,
  input  logic dbg_finish_i,
  output logic esc_o
);
  localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};
  localparam logic [WAIT_W-1:0] LIMIT_V = WAIT_W'(WAIT_LIMIT);

  logic [WAIT_W-1:0] cnt_q;
  logic              esc_q;
  logic              refused;

  assign refused = dbg_req_i & ~dbg_sel_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (refused) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      esc_q <= 1'b0;
    else if (!dbg_req_i || dbg_finish_i)
      esc_q <= 1'b0;
    else if (refused && (cnt_q >= LIMIT_V))
      esc_q <= 1'b1;
  end

  assign esc_o = esc_q;

  // R7: the count holds at its ceiling while refusals continue
  assert_wait_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (refused && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R7: a cycle without refusal restarts the count
  assert_wait_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!refused) |=> (cnt_q == '0));

  // R5: escalation only rises after enough refusals
  assert_esc_entry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(esc_q) |-> ($past(cnt_q) >= LIMIT_V));
endmodule

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter
  import boa_pkg::*;
#(
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned WAIT_LIMIT = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] req_i,
  input  logic [2:0] done_i,
  input  logic       cop_special_i,
  output logic [2:0] grant_o,
  output logic [2:0] stall_o
);
  mvec_t grant_q;
  mvec_t grant_nxt;
  mvec_t stall_q;
  logic  handover;
  logic  dbg_finish;
  logic  esc;
  logic  esc_eff;
  logic  past_live;

  boa_handover u_handover (
    .grant_q      (grant_q),
    .req_i        (req_i),
    .done_i       (done_i),
    .handover_o   (handover),
    .dbg_finish_o (dbg_finish)
  );

  // An escalation whose transfer ends now no longer takes precedence.
  assign esc_eff = esc & ~dbg_finish;

  boa_pick u_pick (
    .handover_i  (handover),
    .grant_q     (grant_q),
    .req_i       (req_i),
    .special_i   (cop_special_i),
    .esc_eff_i   (esc_eff),
    .grant_nxt_o (grant_nxt)
  );

  boa_wait_tracker #(
    .WAIT_W     (WAIT_W),
    .WAIT_LIMIT (WAIT_LIMIT)
  ) u_wait (
    .clk          (clk),
    .rst          (rst),
    .dbg_req_i    (req_i[M_DBG]),
    .dbg_sel_i    (grant_nxt[M_DBG]),
    .dbg_finish_i (dbg_finish),
    .esc_o        (esc)
  );

  always_ff @(posedge clk) begin
    if (rst) grant_q <= '0;
    else     grant_q <= grant_nxt;
  end

  for (genvar m = 0; m < int'(N_MST); m++) begin : g_stall
    always_ff @(posedge clk) begin
      if (rst) stall_q[m] <= 1'b0;
      else     stall_q[m] <= req_i[m] & ~grant_nxt[m];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) past_live <= 1'b0;
    else     past_live <= 1'b1;
  end

  assign grant_o = grant_q;
  assign stall_o = stall_q;

  // R1: never two owners
  assert_one_owner_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));

  // R2: an owner mid-transfer keeps the bus
  assert_no_split_R2: assert property (@(posedge clk) disable iff (rst)
    (|(grant_q & req_i & ~done_i)) |=> $stable(grant_q));

  // R4: special coprocessor access wins any handover
  assert_special_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (handover && req_i[M_COP] && cop_special_i) |=> grant_q[M_COP]);

  // R5: escalated debug takes the handover unless a special access competes
  assert_escalate_R5: assert property (@(posedge clk) disable iff (rst)
    (handover && esc_eff && req_i[M_DBG] && !(req_i[M_COP] && cop_special_i))
      |=> grant_q[M_DBG]);

  // R8: stall reflects the previous request and the present grant
  assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
    past_live |-> (stall_q == ($past(req_i) & ~grant_q)));
endmodule

// File: tb/test_bus_owner_arbiter.sv
`timescale 1ns/1ps
module test_bus_owner_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = '0;
  logic [2:0] done = '0;
  logic       sp = 1'b0;
  logic [2:0] grant;
  logic [2:0] stall;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  string tag = "R9";

  // behavioural reference state
  int owner = -1;
  int wcnt = 0;
  bit esc_m = 0;
  logic [2:0] exp_g = '0;
  logic [2:0] exp_s = '0;

  bit dbg_got = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_owner_arbiter i_bus_owner_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .done_i(done),
    .cop_special_i(sp), .grant_o(grant), .stall_o(stall)
  );

  task automatic check(input string t, input logic [2:0] act, input logic [2:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b cycle=%0d", t, what, act, exp, cycles);
    end
  endtask

  task automatic model_step();
    bit free;
    bit eff;
    int nxt;
    bit denied;
    if (rst) begin
      owner = -1; wcnt = 0; esc_m = 0; exp_g = '0; exp_s = '0;
      return;
    end
    free = (owner < 0) || !req[owner] || done[owner];
    eff = esc_m && !(owner == 2 && done[2]);
    nxt = owner;
    if (free) begin
      if (req[1] && sp) nxt = 1;
      else if (eff && req[2]) nxt = 2;
      else if (req[0]) nxt = 0;
      else if (req[1]) nxt = 1;
      else if (req[2]) nxt = 2;
      else nxt = -1;
    end
    denied = req[2] && (nxt != 2);
    if (!req[2] || (owner == 2 && done[2])) esc_m = 0;
    else if (denied && wcnt >= 128) esc_m = 1;
    wcnt = denied ? ((wcnt < 255) ? wcnt + 1 : 255) : 0;
    owner = nxt;
    exp_g = (nxt < 0) ? 3'b000 : (3'b001 << nxt);
    exp_s = req & ~exp_g;
  endtask

  task automatic step(input logic [2:0] r, input logic [2:0] d, input logic s);
    req = r; done = d; sp = s;
    @(posedge clk);
    cycles++;
    model_step();
    #1;
    check(tag, grant, exp_g, "grant");
    check(tag, stall, exp_s, "stall");
    if (grant[2]) dbg_got = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R9: reset state
    tag = "R9";
    step(3'b111, 3'b000, 1'b1);
    step(3'b111, 3'b000, 1'b0);
    rst = 1'b0;
    step(3'b000, 3'b000, 1'b0);
    check("R9", grant, 3'b000, "grant after reset");

    // R3: single requests and normal ranking
    tag = "R3";
    step(3'b100, 3'b000, 0);
    check("R3", grant, 3'b100, "debug alone");
    step(3'b000, 3'b000, 0);
    step(3'b010, 3'b000, 0);
    step(3'b000, 3'b000, 0);
    step(3'b111, 3'b000, 0);
    check("R3", grant, 3'b001, "main first");

    // R2: hold mid-transfer, foreign done ignored
    tag = "R2";
    step(3'b111, 3'b110, 0);
    check("R2", grant, 3'b001, "foreign done ignored");
    step(3'b111, 3'b000, 0);
    step(3'b111, 3'b001, 0);
    check("R2", grant, 3'b001, "main wins again at its done");
    step(3'b110, 3'b000, 0);
    check("R3", grant, 3'b010, "coprocessor over debug");
    step(3'b110, 3'b000, 0);
    check("R8", stall, 3'b100, "debug stalled");
    step(3'b100, 3'b000, 0);
    check("R3", grant, 3'b100, "debug last");
    step(3'b000, 3'b100, 0);

    // R4: special coprocessor access waits for main's done, then wins
    tag = "R4";
    step(3'b001, 3'b000, 0);
    step(3'b011, 3'b000, 1);
    check("R4", grant, 3'b001, "main not cut off");
    step(3'b011, 3'b001, 1);
    check("R4", grant, 3'b010, "special wins");
    step(3'b011, 3'b000, 1);
    check("R4", stall, 3'b001, "main stalled");
    step(3'b001, 3'b010, 0);
    step(3'b000, 3'b001, 0);
    step(3'b000, 3'b000, 0);

    // R5/R6: escalation under a continuously busy main master
    tag = "R5";
    dbg_got = 0;
    step(3'b001, 3'b000, 0);
    for (int i = 0; i < 160 && !dbg_got; i++) begin
      step(3'b101, ((i % 4) == 3) ? 3'b001 : 3'b000, 0);
    end
    check("R5", {2'b00, dbg_got}, 3'b001, "debug escalated to owner");
    tag = "R6";
    step(3'b101, 3'b001, 0);
    check("R6", grant, 3'b100, "escalated debug keeps bus");
    step(3'b101, 3'b000, 0);
    step(3'b101, 3'b100, 0);
    check("R6", grant, 3'b001, "normal priority after escalated done");
    step(3'b001, 3'b001, 0);
    step(3'b000, 3'b000, 0);

    // R7: broken wait does not escalate
    tag = "R7";
    dbg_got = 0;
    for (int i = 0; i < 100; i++) step(3'b101, ((i % 4) == 3) ? 3'b001 : 3'b000, 0);
    step(3'b001, 3'b000, 0);
    for (int i = 0; i < 100; i++) step(3'b101, ((i % 4) == 3) ? 3'b001 : 3'b000, 0);
    check("R7", {2'b00, dbg_got}, 3'b000, "no escalation after restart");
    step(3'b000, 3'b001, 0);
    step(3'b000, 3'b000, 0);

    // R4/R5: special access beats an escalated debug master
    tag = "R4";
    dbg_got = 0;
    step(3'b001, 3'b000, 0);
    for (int i = 0; i < 135; i++) step(3'b101, 3'b000, 0);
    step(3'b111, 3'b001, 1);
    check("R4", grant, 3'b010, "special over escalated debug");
    tag = "R5";
    step(3'b101, 3'b010, 0);
    check("R5", grant, 3'b100, "escalated debug next");
    step(3'b000, 3'b100, 0);
    step(3'b000, 3'b000, 0);
    check("R3", grant, 3'b000, "idle bus");

    finish_run();
  end
endmodule